// File: doc/BRIEF.md
# Endpoint Transaction Handshake Controller

This block decides, for a full-speed device with eight endpoint slots, how each decoded bus token is answered. Each slot holds a buffer segment, a payload length, a direction, an isochronous flag, a data-toggle bit and stall controls. When a SETUP, IN or OUT token arrives, the slot whose endpoint-number field matches the token is selected. The controller picks the answer (ACK, NAK, STALL, a data packet, or silence) and points the packet engine at the slot's buffer. It supplies the DATA0/DATA1 choice and the transmit length for IN data. It also records a 3-bit outcome code per slot and a global overrun flag. Serialization and CRC belong to neighbouring blocks.

Firmware arms a slot by writing its payload length. The hardware then disarms the slot once the transaction completes. After an OUT transaction, the length field holds the byte count actually received. A side read port lets the owner inspect any slot.

Top module: `ep_handshake_ctrl`

## Requirements
- R1: For an answered IN or OUT transaction, `buf_addr` equals `SRAM_BASE` plus the slot's 6-bit segment times 8. For SETUP, the separate setup segment is used with the same rule.
- R2: A configuration write with field code 1 (length, data bits [8:0]) arms the slot. An IN token on an armed, unstalled IN slot returns response code 4 (DATA), with `tx_len` equal to the written length.
- R3: An OUT token on an armed, unstalled OUT slot returns ACK (code 1) and disarms the slot. The slot length then reads back as `rx_count`. The outcome code is 010 for received PID 0 and 110 for received PID 1.
- R4: Field code 3 (command) with data bit 0 set disarms the slot, and data bit 1 sets the stall state. In readback, bit 0 of `rd_cmd` is always 0 and bit 1 shows the stall state.
- R5: Field code 2 (control) holds the endpoint number in bits [3:0], the isochronous flag in bit 4, the direction in [6:5], the toggle in bit 7 and the stall-release-on-SETUP enable in bit 8. Direction 01 means OUT and 10 means IN; 00 and 11 mean disabled. A token matching no enabled slot, or whose type differs from the slot direction, gets response 0 and no event. When two enabled slots share a number, the lower slot index answers.
- R6: A stalled slot answers IN and OUT tokens with STALL (code 3). A SETUP on a slot with the release enable set clears the stall.
- R7: A SETUP token to a matching slot is always answered with ACK, whatever the slot's stall or arm state. It records code 011 with an event.
- R8: `overrun` is written at every completed OUT or SETUP. It is 1 when an OUT byte count exceeds the armed length or when a SETUP count exceeds 8, and 0 otherwise.
- R9: IN data carries the slot's toggle on `tx_pid`. A `host_ack` pulse on a later cycle with no token flips the toggle, disarms the slot and raises an event with code 000. If another token arrives first, the slot stays armed and keeps its toggle.
- R10: An isochronous slot sends no handshake: an armed OUT returns response 0. An armed IN returns DATA and finishes at once. Both disarm the slot, record code 111 and raise an event, and the toggle does not change.
- R11: An enabled, unstalled but unarmed slot answers with NAK (code 2). On IN this records code 001 with an event; on OUT no event is raised.
- R12: Response, event, buffer and overrun outputs are registered one cycle after the token. On any cycle after a cycle with no token, the response is 0 (none). After reset, every output and every slot field is 0.
- R13: Field code 0 writes the slot segment from data bits [5:0]. Field code 4 writes the setup segment from data bits [5:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_slot | input | 3 | Slot written |
| cfg_field | input | 3 | Field code (0 segment, 1 length, 2 control, 3 command, 4 setup segment) |
| cfg_wdata | input | 9 | Write data |
| tok_valid | input | 1 | Token (with its data phase) complete this cycle |
| tok_type | input | 2 | 1 SETUP, 2 IN, 3 OUT |
| tok_ep | input | 4 | Token endpoint number |
| rx_pid | input | 1 | Received data PID (0 DATA0, 1 DATA1) |
| rx_count | input | 9 | Received byte count |
| host_ack | input | 1 | Host acknowledged the last IN data |
| rsp_code | output | 3 | 0 none, 1 ACK, 2 NAK, 3 STALL, 4 DATA |
| tx_pid | output | 1 | Toggle for IN data |
| buf_addr | output | 12 | Buffer start address |
| tx_len | output | 9 | IN data length |
| ev_valid | output | 1 | Event pulse |
| ev_slot | output | 3 | Slot of the event |
| ev_code | output | 3 | Outcome code of the event |
| overrun | output | 1 | Last completed receive overran |
| rd_slot | input | 3 | Slot to inspect |
| rd_len | output | 9 | Length field |
| rd_armed | output | 1 | Armed state |
| rd_sync | output | 1 | Toggle bit |
| rd_stall | output | 1 | Stall state |
| rd_code | output | 3 | Last outcome code |
| rd_cmd | output | 2 | Command readback {stall, 0} |

## Verification
The hardest state to reach is an IN transfer left hanging: data has gone out and the host acknowledgement is still owed. In that state, either the acknowledgement arrives or an unrelated token takes its place, and the toggle must then flip or stay put. Random stimulus mixes tokens, acknowledgement pulses and reconfiguration on a small pool of shared endpoint numbers. Pending IN transfers are therefore often overtaken. A directed sequence forces the retry case, the duplicate-number priority, the undefined direction code and clear-ready.

// File: rtl/ep_hs_pkg.sv
// Shared encodings for the endpoint handshake controller.
package ep_hs_pkg;
    typedef enum logic [1:0] {TOK_NONE = 2'd0, TOK_SETUP = 2'd1, TOK_IN = 2'd2, TOK_OUT = 2'd3} tok_e;
    typedef enum logic [2:0] {RSP_NONE = 3'd0, RSP_ACK = 3'd1, RSP_NAK = 3'd2,
                              RSP_STALL = 3'd3, RSP_DATA = 3'd4} rsp_e;
    typedef enum logic [2:0] {FLD_SEG = 3'd0, FLD_LEN = 3'd1, FLD_CTRL = 3'd2,
                              FLD_CMD = 3'd3, FLD_SETUP_SEG = 3'd4} fld_e;
    typedef enum logic [1:0] {DIR_OFF = 2'd0, DIR_OUT = 2'd1, DIR_IN = 2'd2, DIR_BAD = 2'd3} dir_e;

    localparam logic [2:0] ST_IN_ACK  = 3'b000;
    localparam logic [2:0] ST_IN_NAK  = 3'b001;
    localparam logic [2:0] ST_OUT_D0  = 3'b010;
    localparam logic [2:0] ST_SETUP   = 3'b011;
    localparam logic [2:0] ST_OUT_D1  = 3'b110;
    localparam logic [2:0] ST_ISO_END = 3'b111;

    // Per-slot state change requested by the transaction logic.
    typedef struct packed {
        logic       disarm;
        logic       len_en;
        logic       flip;
        logic       clr_stall;
        logic       code_en;
        logic [2:0] code;
    } upd_t;
endpackage

// File: rtl/ep_hs_slot.sv
// One endpoint slot: holds configuration, arm state, toggle, stall and last
// outcome. Assumes a configuration write and a transaction update may hit the
// same cycle; the configuration write then wins for any field both touch.
module ep_hs_slot import ep_hs_pkg::*; #(
    parameter int EPN_W = 4,
    parameter int SEG_W = 6,
    parameter int LEN_W = 9,
    parameter int CFG_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_field,
    input  logic [CFG_W-1:0] wr_data,
    input  logic             upd_en,
    input  upd_t             upd,
    input  logic [LEN_W-1:0] upd_len,
    output logic [EPN_W-1:0] epnum,
    output logic             iso,
    output logic [1:0]       dir,
    output logic             sync,
    output logic             clr_stall_en,
    output logic             stall,
    output logic             armed,
    output logic [LEN_W-1:0] len,
    output logic [SEG_W-1:0] seg,
    output logic [2:0]       code
);
    // Slot register update: transaction results first, then firmware writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epnum        <= '0;
            iso          <= 1'b0;
            dir          <= DIR_OFF;
            sync         <= 1'b0;
            clr_stall_en <= 1'b0;
            stall        <= 1'b0;
            armed        <= 1'b0;
            len          <= '0;
            seg          <= '0;
            code         <= '0;
        end else begin
            if (upd_en) begin
                if (upd.code_en)   code  <= upd.code;
                if (upd.disarm)    armed <= 1'b0;
                if (upd.len_en)    len   <= upd_len;
                if (upd.flip)      sync  <= ~sync;
                if (upd.clr_stall) stall <= 1'b0;
            end
            if (wr_en) begin
                case (fld_e'(wr_field))
                    FLD_SEG: seg <= wr_data[SEG_W-1:0];
                    FLD_LEN: begin
                        len   <= wr_data[LEN_W-1:0];
                        armed <= 1'b1;
                    end
                    FLD_CTRL: begin
                        epnum        <= wr_data[EPN_W-1:0];
                        iso          <= wr_data[EPN_W];
                        dir          <= wr_data[EPN_W+2:EPN_W+1];
                        sync         <= wr_data[EPN_W+3];
                        clr_stall_en <= wr_data[EPN_W+4];
                    end
                    FLD_CMD: begin
                        if (wr_data[0]) armed <= 1'b0;
                        stall <= wr_data[1];
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/ep_hs_match.sv
// Selects the slot answering a token: the lowest-index enabled slot whose
// endpoint-number field equals the token number. Purely combinational.
module ep_hs_match import ep_hs_pkg::*; #(
    parameter int NUM_EP = 8,
    parameter int EPN_W  = 4,
    parameter int SLOT_W = 3
) (
    input  logic [EPN_W-1:0]             tok_ep,
    input  logic [NUM_EP-1:0][EPN_W-1:0] epnum,
    input  logic [NUM_EP-1:0][1:0]       dir,
    output logic                         hit,
    output logic [SLOT_W-1:0]            slot
);
    // Scan downwards so the lowest matching index is the last to win.
    always_comb begin
        hit  = 1'b0;
        slot = '0;
        for (int i = NUM_EP - 1; i >= 0; i--) begin
            if ((dir[i] == DIR_OUT || dir[i] == DIR_IN) && epnum[i] == tok_ep) begin
                hit  = 1'b1;
                slot = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/ep_hs_decide.sv
// Handshake decision for one token against the selected slot. Assumes the
// token's data phase is complete (rx_count, rx_pid valid) when tok_valid is high.
module ep_hs_decide import ep_hs_pkg::*; #(
    parameter int              SEG_W       = 6,
    parameter int              LEN_W       = 9,
    parameter int              ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] SRAM_BASE = '0,
    parameter int              SETUP_LIMIT = 8
) (
    input  logic              tok_valid,
    input  logic [1:0]        tok_type,
    input  logic              rx_pid,
    input  logic [LEN_W-1:0]  rx_count,
    input  logic              hit,
    input  logic              iso,
    input  logic [1:0]        dir,
    input  logic              sync,
    input  logic              clr_stall_en,
    input  logic              stall,
    input  logic              armed,
    input  logic [LEN_W-1:0]  len,
    input  logic [SEG_W-1:0]  seg,
    input  logic [SEG_W-1:0]  setup_seg,
    output rsp_e              rsp,
    output logic              ev,
    output logic [2:0]        code,
    output upd_t              upd,
    output logic [LEN_W-1:0]  upd_len,
    output logic              ovr_en,
    output logic              ovr_val,
    output logic              pend_start,
    output logic              tx_pid,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [LEN_W-1:0]  tx_len
);
    localparam int PAD_W = ADDR_W - SEG_W - 3;

    // Response, outcome code and slot update for the current token.
    always_comb begin
        rsp        = RSP_NONE;
        ev         = 1'b0;
        code       = ST_IN_ACK;
        upd        = '0;
        upd_len    = rx_count;
        ovr_en     = 1'b0;
        ovr_val    = 1'b0;
        pend_start = 1'b0;
        tx_pid     = sync;
        tx_len     = len;
        buf_addr   = SRAM_BASE + {{PAD_W{1'b0}}, seg, 3'b000};
        if (tok_valid && hit) begin
            case (tok_e'(tok_type))
                TOK_SETUP: begin
                    rsp           = RSP_ACK;
                    buf_addr      = SRAM_BASE + {{PAD_W{1'b0}}, setup_seg, 3'b000};
                    ev            = 1'b1;
                    code          = ST_SETUP;
                    upd.clr_stall = clr_stall_en;
                    ovr_en        = 1'b1;
                    ovr_val       = (rx_count > LEN_W'(SETUP_LIMIT));
                end
                TOK_IN: begin
                    if (dir == DIR_IN) begin
                        if (stall) begin
                            rsp = RSP_STALL;
                        end else if (!armed) begin
                            rsp  = RSP_NAK;
                            ev   = 1'b1;
                            code = ST_IN_NAK;
                        end else begin
                            rsp = RSP_DATA;
                            if (iso) begin
                                ev         = 1'b1;
                                code       = ST_ISO_END;
                                upd.disarm = 1'b1;
                            end else begin
                                pend_start = 1'b1;
                            end
                        end
                    end
                end
                TOK_OUT: begin
                    if (dir == DIR_OUT) begin
                        if (stall) begin
                            rsp = RSP_STALL;
                        end else if (!armed) begin
                            rsp = RSP_NAK;
                        end else begin
                            rsp        = iso ? RSP_NONE : RSP_ACK;
                            ev         = 1'b1;
                            code       = iso ? ST_ISO_END : (rx_pid ? ST_OUT_D1 : ST_OUT_D0);
                            upd.disarm = 1'b1;
                            upd.len_en = 1'b1;
                            ovr_en     = 1'b1;
                            ovr_val    = (rx_count > len);
                        end
                    end
                end
                default: ;
            endcase
            upd.code_en = ev;
            upd.code    = code;
        end
    end
endmodule

// File: rtl/ep_handshake_ctrl.sv
// Top of the endpoint handshake controller: slot array, token matching,
// decision, pending-IN tracking and registered outputs. Assumes host_ack is
// only presented on cycles without a token.
module ep_handshake_ctrl import ep_hs_pkg::*; #(
    parameter int                NUM_EP      = 8,
    parameter int                EPN_W       = 4,
    parameter int                SEG_W       = 6,
    parameter int                LEN_W       = 9,
    parameter int                ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] SRAM_BASE   = 'h400,
    parameter int                SETUP_LIMIT = 8,
    localparam int               SLOT_W      = $clog2(NUM_EP),
    localparam int               CFG_W       = (LEN_W > EPN_W + 5) ? LEN_W : EPN_W + 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [2:0]        cfg_field,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              tok_valid,
    input  logic [1:0]        tok_type,
    input  logic [EPN_W-1:0]  tok_ep,
    input  logic              rx_pid,
    input  logic [LEN_W-1:0]  rx_count,
    input  logic              host_ack,
    output logic [2:0]        rsp_code,
    output logic              tx_pid,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [LEN_W-1:0]  tx_len,
    output logic              ev_valid,
    output logic [SLOT_W-1:0] ev_slot,
    output logic [2:0]        ev_code,
    output logic              overrun,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [LEN_W-1:0]  rd_len,
    output logic              rd_armed,
    output logic              rd_sync,
    output logic              rd_stall,
    output logic [2:0]        rd_code,
    output logic [1:0]        rd_cmd
);
    logic [NUM_EP-1:0][EPN_W-1:0] s_ep;
    logic [NUM_EP-1:0][1:0]       s_dir;
    logic [NUM_EP-1:0][LEN_W-1:0] s_len;
    logic [NUM_EP-1:0][SEG_W-1:0] s_seg;
    logic [NUM_EP-1:0][2:0]       s_code;
    logic [NUM_EP-1:0]            s_iso, s_sync, s_clr, s_stall, s_armed;

    logic              m_hit;
    logic [SLOT_W-1:0] m_slot;
    logic [SEG_W-1:0]  setup_seg;
    logic              pend_valid;
    logic [SLOT_W-1:0] pend_slot;
    logic              ack_fire;

    rsp_e              d_rsp;
    logic              d_ev, d_ovr_en, d_ovr_val, d_pend, d_pid;
    logic [2:0]        d_code;
    upd_t              d_upd, ack_upd;
    logic [LEN_W-1:0]  d_upd_len, d_len;
    logic [ADDR_W-1:0] d_addr;

    logic              sel_stall;
    logic [1:0]        sel_dir;

    assign ack_fire  = host_ack && pend_valid && !tok_valid;
    assign sel_stall = s_stall[m_slot];
    assign sel_dir   = s_dir[m_slot];

    // Update requested when the host acknowledges pending IN data.
    always_comb begin
        ack_upd         = '0;
        ack_upd.disarm  = 1'b1;
        ack_upd.flip    = 1'b1;
        ack_upd.code_en = 1'b1;
        ack_upd.code    = ST_IN_ACK;
    end

    for (genvar g = 0; g < NUM_EP; g++) begin : g_slot
        logic slot_wr, slot_tok, slot_ack;
        assign slot_wr  = cfg_we && cfg_slot == SLOT_W'(g) && fld_e'(cfg_field) != FLD_SETUP_SEG;
        assign slot_tok = tok_valid && m_hit && m_slot == SLOT_W'(g);
        assign slot_ack = ack_fire && pend_slot == SLOT_W'(g);
        ep_hs_slot #(.EPN_W(EPN_W), .SEG_W(SEG_W), .LEN_W(LEN_W), .CFG_W(CFG_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .wr_en(slot_wr), .wr_field(cfg_field), .wr_data(cfg_wdata),
            .upd_en(slot_tok || slot_ack),
            .upd(slot_ack ? ack_upd : d_upd),
            .upd_len(d_upd_len),
            .epnum(s_ep[g]), .iso(s_iso[g]), .dir(s_dir[g]), .sync(s_sync[g]),
            .clr_stall_en(s_clr[g]), .stall(s_stall[g]), .armed(s_armed[g]),
            .len(s_len[g]), .seg(s_seg[g]), .code(s_code[g])
        );
    end

    ep_hs_match #(.NUM_EP(NUM_EP), .EPN_W(EPN_W), .SLOT_W(SLOT_W)) u_match (
        .tok_ep(tok_ep), .epnum(s_ep), .dir(s_dir), .hit(m_hit), .slot(m_slot)
    );

    ep_hs_decide #(.SEG_W(SEG_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W),
                   .SRAM_BASE(SRAM_BASE), .SETUP_LIMIT(SETUP_LIMIT)) u_decide (
        .tok_valid(tok_valid), .tok_type(tok_type), .rx_pid(rx_pid), .rx_count(rx_count),
        .hit(m_hit), .iso(s_iso[m_slot]), .dir(sel_dir), .sync(s_sync[m_slot]),
        .clr_stall_en(s_clr[m_slot]), .stall(sel_stall), .armed(s_armed[m_slot]),
        .len(s_len[m_slot]), .seg(s_seg[m_slot]), .setup_seg(setup_seg),
        .rsp(d_rsp), .ev(d_ev), .code(d_code), .upd(d_upd), .upd_len(d_upd_len),
        .ovr_en(d_ovr_en), .ovr_val(d_ovr_val), .pend_start(d_pend),
        .tx_pid(d_pid), .buf_addr(d_addr), .tx_len(d_len)
    );

    // Setup segment register, written through its own field code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            setup_seg <= '0;
        else if (cfg_we && fld_e'(cfg_field) == FLD_SETUP_SEG)
            setup_seg <= cfg_wdata[SEG_W-1:0];
    end

    // Registered token results, event pulse, overrun flag and pending IN.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_code   <= RSP_NONE;
            tx_pid     <= 1'b0;
            buf_addr   <= '0;
            tx_len     <= '0;
            ev_valid   <= 1'b0;
            ev_slot    <= '0;
            ev_code    <= '0;
            overrun    <= 1'b0;
            pend_valid <= 1'b0;
            pend_slot  <= '0;
        end else begin
            rsp_code <= tok_valid ? d_rsp : RSP_NONE;
            if (tok_valid && m_hit) begin
                tx_pid   <= d_pid;
                buf_addr <= d_addr;
                tx_len   <= d_len;
            end
            ev_valid <= d_ev || ack_fire;
            ev_slot  <= ack_fire ? pend_slot : m_slot;
            ev_code  <= ack_fire ? ST_IN_ACK : d_code;
            if (d_ovr_en) overrun <= d_ovr_val;
            if (tok_valid) begin
                pend_valid <= d_pend;
                pend_slot  <= m_slot;
            end else if (ack_fire) begin
                pend_valid <= 1'b0;
            end
        end
    end

    // Side readback of one slot.
    assign rd_len   = s_len[rd_slot];
    assign rd_armed = s_armed[rd_slot];
    assign rd_sync  = s_sync[rd_slot];
    assign rd_stall = s_stall[rd_slot];
    assign rd_code  = s_code[rd_slot];
    assign rd_cmd   = {s_stall[rd_slot], 1'b0};
endmodule

// File: rtl/ep_hs_checker.sv
// Temporal checks on the handshake controller, bound to every instance.
module ep_hs_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tok_valid,
    input logic [1:0] tok_type,
    input logic       m_hit,
    input logic [1:0] sel_dir,
    input logic       sel_stall,
    input logic       host_ack,
    input logic       pend_valid,
    input logic [2:0] rsp_code,
    input logic       ev_valid,
    input logic [2:0] ev_code
);
    // R12: no token, no answer on the following cycle.
    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_valid |=> rsp_code == 3'd0);

    // R7: a matched SETUP is acknowledged and logged as setup.
    p_setup_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_type == 2'd1 && m_hit) |=> (rsp_code == 3'd1 && ev_valid && ev_code == 3'b011));

    // R5: an unmatched token stays silent.
    p_nohit_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && !m_hit) |=> (rsp_code == 3'd0 && !ev_valid));

    // R6: stalled IN slot answers STALL.
    p_stall_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok_type == 2'd2 && m_hit && sel_dir == 2'd2 && sel_stall) |=> rsp_code == 3'd3);

    // R9: host acknowledgement of pending data produces an IN ACK event.
    p_ack_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && pend_valid && !tok_valid) |=> (ev_valid && ev_code == 3'b000));

    // R11: event codes stay within the defined set.
    p_code_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ev_valid |-> (ev_code != 3'b100 && ev_code != 3'b101));
endmodule

bind ep_handshake_ctrl ep_hs_checker u_hs_chk (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_type(tok_type),
    .m_hit(m_hit), .sel_dir(sel_dir), .sel_stall(sel_stall),
    .host_ack(host_ack), .pend_valid(pend_valid),
    .rsp_code(rsp_code), .ev_valid(ev_valid), .ev_code(ev_code)
);

// File: tb/ep_handshake_ctrl_bench.sv
module ep_handshake_ctrl_bench;
    localparam int BASE = 'h400;

    logic       clk = 0, rst_n = 0;
    logic       cfg_we = 0;
    logic [2:0] cfg_slot = 0, cfg_field = 0;
    logic [8:0] cfg_wdata = 0;
    logic       tok_valid = 0;
    logic [1:0] tok_type = 0;
    logic [3:0] tok_ep = 0;
    logic       rx_pid = 0;
    logic [8:0] rx_count = 0;
    logic       host_ack = 0;
    logic [2:0] rsp_code, ev_slot, ev_code, rd_code, rd_slot = 0;
    logic       tx_pid, ev_valid, overrun, rd_armed, rd_sync, rd_stall;
    logic [11:0] buf_addr;
    logic [8:0] tx_len, rd_len;
    logic [1:0] rd_cmd;

    ep_handshake_ctrl u_ep_handshake_ctrl (.*);

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 0;

    // Bench model of every slot, kept from the requirements.
    int m_ep[8], m_iso[8], m_dir[8], m_sync[8], m_clr[8], m_stall[8], m_armed[8];
    int m_len[8], m_seg[8], m_code[8];
    int m_setup_seg = 0, m_pend = 0, m_pslot = 0, m_ovr = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(int slot, int field, int data);
        @(negedge clk);
        cfg_we = 1; cfg_slot = 3'(slot); cfg_field = 3'(field); cfg_wdata = 9'(data);
        @(negedge clk);
        cfg_we = 0;
        case (field)
            0: m_seg[slot] = data & 63;
            1: begin m_len[slot] = data & 511; m_armed[slot] = 1; end
            2: begin
                m_ep[slot] = data & 15; m_iso[slot] = (data >> 4) & 1; m_dir[slot] = (data >> 5) & 3;
                m_sync[slot] = (data >> 7) & 1; m_clr[slot] = (data >> 8) & 1;
            end
            3: begin if (data & 1) m_armed[slot] = 0; m_stall[slot] = (data >> 1) & 1; end
            4: m_setup_seg = data & 63;
            default: ;
        endcase
    endtask

    task automatic rd_check(int slot, string req);
        rd_slot = 3'(slot);
        #0.5;
        chk(rd_len == 9'(m_len[slot]), req, "rd_len", rd_len, m_len[slot]);
        chk(rd_armed == 1'(m_armed[slot]), req, "rd_armed", rd_armed, m_armed[slot]);
        chk(rd_sync == 1'(m_sync[slot]), req, "rd_sync", rd_sync, m_sync[slot]);
        chk(rd_stall == 1'(m_stall[slot]), req, "rd_stall", rd_stall, m_stall[slot]);
        chk(rd_code == 3'(m_code[slot]), req, "rd_code", rd_code, m_code[slot]);
        chk(rd_cmd == {1'(m_stall[slot]), 1'b0}, "R4", "rd_cmd", rd_cmd, m_stall[slot] * 2);
    endtask

    task automatic token(int typ, int ep, int pid, int cnt, string req);
        int hit = 0, s = 0, e_rsp = 0, e_ev = 0, e_code = 0, e_addr = 0, e_pend = 0;
        for (int i = 0; i < 8; i++)
            if (hit == 0 && (m_dir[i] == 1 || m_dir[i] == 2) && m_ep[i] == ep) begin hit = 1; s = i; end
        if (hit != 0) begin
            e_addr = BASE + m_seg[s] * 8;
            case (typ)
                1: begin
                    e_rsp = 1; e_ev = 1; e_code = 3; e_addr = BASE + m_setup_seg * 8;
                    if (m_clr[s] != 0) m_stall[s] = 0;
                    m_ovr = (cnt > 8);
                end
                2: if (m_dir[s] == 2) begin
                    if (m_stall[s] != 0) e_rsp = 3;
                    else if (m_armed[s] == 0) begin e_rsp = 2; e_ev = 1; e_code = 1; end
                    else begin
                        e_rsp = 4;
                        if (m_iso[s] != 0) begin e_ev = 1; e_code = 7; m_armed[s] = 0; end
                        else e_pend = 1;
                    end
                end
                3: if (m_dir[s] == 1) begin
                    if (m_stall[s] != 0) e_rsp = 3;
                    else if (m_armed[s] == 0) e_rsp = 2;
                    else begin
                        e_rsp = (m_iso[s] != 0) ? 0 : 1; e_ev = 1;
                        e_code = (m_iso[s] != 0) ? 7 : (pid != 0 ? 6 : 2);
                        m_ovr = (cnt > m_len[s]);
                        m_armed[s] = 0; m_len[s] = cnt;
                    end
                end
                default: ;
            endcase
            if (e_ev != 0) m_code[s] = e_code;
        end
        @(negedge clk);
        tok_valid = 1; tok_type = 2'(typ); tok_ep = 4'(ep); rx_pid = 1'(pid); rx_count = 9'(cnt);
        @(negedge clk);
        tok_valid = 0;
        chk(rsp_code == 3'(e_rsp), req, "rsp_code", rsp_code, e_rsp);
        chk(ev_valid == 1'(e_ev), req, "ev_valid", ev_valid, e_ev);
        if (e_ev != 0) begin
            chk(ev_code == 3'(e_code), req, "ev_code", ev_code, e_code);
            chk(ev_slot == 3'(s), req, "ev_slot", ev_slot, s);
        end
        if (e_rsp == 1 || e_rsp == 4)
            chk(buf_addr == 12'(e_addr), "R1", "buf_addr", buf_addr, e_addr);
        if (e_rsp == 4) begin
            chk(tx_pid == 1'(m_sync[s]), "R9", "tx_pid", tx_pid, m_sync[s]);
            chk(tx_len == 9'(m_len[s]), "R2", "tx_len", tx_len, m_len[s]);
        end
        chk(overrun == 1'(m_ovr), "R8", "overrun", overrun, m_ovr);
        m_pend = e_pend; m_pslot = s;
    endtask

    task automatic hack(string req);
        int e_ev = m_pend;
        int s = m_pslot;
        @(negedge clk);
        host_ack = 1;
        @(negedge clk);
        host_ack = 0;
        chk(ev_valid == 1'(e_ev), req, "ack ev_valid", ev_valid, e_ev);
        if (e_ev != 0) begin
            m_sync[s] ^= 1; m_armed[s] = 0; m_code[s] = 0; m_pend = 0;
            chk(ev_code == 3'd0 && ev_slot == 3'(s), req, "ack ev_code", ev_code, 0);
            rd_check(s, req);
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #400000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 8; i++) begin
            m_ep[i] = 0; m_iso[i] = 0; m_dir[i] = 0; m_sync[i] = 0; m_clr[i] = 0;
            m_stall[i] = 0; m_armed[i] = 0; m_len[i] = 0; m_seg[i] = 0; m_code[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R12 reset state
        chk(rsp_code == 0 && ev_valid == 0 && overrun == 0, "R12", "reset outputs", rsp_code, 0);
        rd_check(0, "R12");

        // R13 / R2 / R9: IN slot 1 on endpoint 2, toggle 1
        cfg_write(1, 0, 5);
        cfg_write(4, 4, 9);
        cfg_write(1, 2, 2 | (2 << 5) | (1 << 7));
        token(2, 2, 0, 0, "R11");
        cfg_write(1, 1, 40);
        token(2, 2, 0, 0, "R2");
        token(2, 7, 0, 0, "R9 retry");
        rd_check(1, "R9");
        token(2, 2, 0, 0, "R9");
        hack("R9");
        // R4 clear-ready disarms
        cfg_write(1, 1, 12);
        cfg_write(1, 3, 1);
        rd_check(1, "R4");
        token(2, 2, 0, 0, "R4");
        // R6 stall and release on SETUP
        cfg_write(1, 3, 2);
        cfg_write(1, 1, 8);
        token(2, 2, 0, 0, "R6");
        token(1, 2, 0, 8, "R7");
        cfg_write(1, 2, 2 | (2 << 5) | (1 << 8));
        token(1, 2, 0, 9, "R6");
        rd_check(1, "R6");
        // R3 / R8 OUT on slot 0 endpoint 2: lower index wins (R5)
        cfg_write(0, 2, 2 | (1 << 5));
        cfg_write(0, 1, 16);
        token(3, 2, 1, 20, "R8");
        rd_check(0, "R3");
        cfg_write(0, 1, 64);
        token(3, 2, 0, 10, "R3");
        token(3, 2, 0, 10, "R11");
        // R5 undefined direction
        cfg_write(2, 2, 5 | (3 << 5));
        token(2, 5, 0, 0, "R5");
        token(1, 5, 0, 0, "R5");
        // R10 isochronous
        cfg_write(3, 2, 6 | (1 << 4) | (1 << 5));
        cfg_write(3, 1, 100);
        token(3, 6, 1, 50, "R10");
        cfg_write(3, 2, 6 | (1 << 4) | (2 << 5) | (1 << 7));
        cfg_write(3, 1, 30);
        token(2, 6, 0, 0, "R10");
        rd_check(3, "R10");

        // Random mix
        for (int n = 0; n < 1500; n++) begin
            int r = $urandom % 10;
            int sl = $urandom % 8;
            if (r < 3) begin
                int f = $urandom % 5;
                int d = $urandom % 512;
                if (f == 2) d = (d & 16'h1F0) | ($urandom % 4);
                if (f == 3) d = d & ($urandom % 4 == 0 ? 3 : 1);
                cfg_write(sl, f, d);
            end else if (r < 8) begin
                token(1 + $urandom % 3, $urandom % 5, $urandom % 2, $urandom % 80, "R2 random");
            end else begin
                hack("R9 random");
            end
            rd_check(sl, "R3 random");
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule